// File: doc/BRIEF.md
# DCC Track Waveform Generator with Feedback Cutout

This block turns a model-railway command packet into the two-level track waveform. A microsecond tick sets every duration. Each bit is a high half followed by a low half. A one bit has two short halves and a zero bit has two long halves. A packet is sent as a run of preamble ones. Each byte then follows, led by a zero start bit and sent most significant bit first. One end-of-packet one bit closes the packet.

When the cutout is enabled, a feedback window follows the end-of-packet bit. The window begins after a short guard time. Three strobes mark its start, its midpoint between the two receive windows and its end. The first bit after the window is either an ordinary one bit or a short asymmetric half-zero bit, chosen by a configuration input. The half-zero bit makes older receivers restart their packet parsers.

The block requests a packet with a one-cycle ready pulse at the point where the next packet must begin. The packet bus carries up to `MAX_BYTES` bytes, a byte count and a preamble length. If no packet is offered when one is needed, the block sends an idle packet. `MAX_BYTES` must be at least 3 so that the idle packet fits.

Top module: `dcc_cutout_gen`

## Requirements
- R1: A zero bit drives `track_pol` high for 105 ticks and then low for 105 ticks.
- R2: A one bit drives `track_pol` high for 56 ticks and then low for 56 ticks.
- R3: A packet is sent as follows. First come max(14, `pkt_preamble`) one bits. Then, for each byte from byte 0 (`pkt_bytes[7:0]`) upward, a zero start bit is sent, followed by the byte's eight bits from bit 7 down to bit 0. Last comes one end-of-packet one bit. The byte count is clamped to the range 1 to `MAX_BYTES`.
- R4: `cutout_en` is sampled when the end-of-packet bit finishes. If it is 1, `track_pol` is high for 26 ticks and then `cutout_act` is high for 454 ticks, with `track_pol` held high throughout. If it is 0, the next packet's preamble follows at once.
- R5: `cut_start_stb` is high in the first cycle that `cutout_act` is high. `cut_mid_stb` is high exactly 177 ticks later. `cut_end_stb` is high in the first cycle after `cutout_act` falls, 454 ticks after the start. Each strobe lasts one cycle, and no two strobes are ever high together.
- R6: `half_zero_en` is sampled when the cutout ends. If it is 1, the first bit after the cutout is high for 15 ticks and low for 100 ticks. If it is 0, that bit is an ordinary one bit.
- R7: `pkt_ready` is high for exactly one cycle in each of these cases:
  - the first cycle after reset;
  - the cycle in which the bit after the cutout ends;
  - the cycle in which the end-of-packet bit ends, when there is no cutout.

  `pkt_ready` is never high during the cutout. The bit timer restarts from zero, so the first preamble bit has its full length.
- R8: If `pkt_valid` is low while `pkt_ready` is high, the block sends an idle packet instead. The idle packet is bytes 0xFF, 0x00, 0xFF with a 14-bit preamble.
- R9: During reset, `track_pol`, `cutout_act`, the three strobes and `pkt_ready` are all 0.
- R10: After the initial packet request, `track_pol` changes only in the cycle after a cycle with `tick_us` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| pkt_valid | input | 1 | A packet is offered |
| pkt_ready | output | 1 | Packet taken in this cycle |
| pkt_bytes | input | 8*MAX_BYTES | Packet bytes, byte 0 in the low bits |
| pkt_count | input | CNT_W | Number of bytes |
| pkt_preamble | input | PRE_W | Requested preamble length |
| cutout_en | input | 1 | Insert the feedback cutout after each packet |
| half_zero_en | input | 1 | Send a half-zero bit after the cutout |
| track_pol | output | 1 | Track polarity |
| cutout_act | output | 1 | Output drivers disabled for the cutout |
| cut_start_stb | output | 1 | Cutout start strobe |
| cut_mid_stb | output | 1 | Strobe between the two receive windows |
| cut_end_stb | output | 1 | Cutout end strobe |

## Verification
The packet request at the end of the post-cutout bit falls in the same cycle as the bit timer's reload and the choice between the offered packet and the idle packet. The bench provokes this case by withdrawing `pkt_valid` before one request and by changing the cutout and half-zero settings just after each request. It then judges the result by comparing every measured polarity segment against a sequence rebuilt independently from the packet and settings that were on the inputs at the request. A wrong choice or a leftover partial count shows up as a segment with the wrong length or the wrong level.

// File: rtl/dcc_wave_pkg.sv
package dcc_wave_pkg;

  typedef enum logic [2:0] {PH_INIT, PH_A, PH_B, PH_GAP, PH_WIN1, PH_WIN2} phase_t;
  typedef enum logic [2:0] {ST_PRE, ST_START, ST_DATA, ST_END, ST_POST} stage_t;
  typedef enum logic [1:0] {BK_ONE, BK_ZERO, BK_HALF} kind_t;

  // Ticks in one half of a bit; second selects the low half.
  function automatic int half_ticks(kind_t k, logic second, int one_h, int zero_h,
                                    int hz_hi, int hz_lo);
    case (k)
      BK_ZERO: return zero_h;
      BK_HALF: return second ? hz_lo : hz_hi;
      default: return one_h;
    endcase
  endfunction

  function automatic int clamp_count(int c, int max_b);
    if (c < 1) return 1;
    if (c > max_b) return max_b;
    return c;
  endfunction

  function automatic int clamp_pre(int p, int min_p);
    return (p < min_p) ? min_p : p;
  endfunction

endpackage

// File: rtl/dcc_seg_timer.sv
module dcc_seg_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [TW-1:0] len,
  output logic          seg_end
);

  logic [TW-1:0] cnt;

  assign seg_end = tick && !restart && (cnt == len - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart || seg_end) cnt <= '0;
    else if (tick)               cnt <= cnt + TW'(1);
  end

endmodule

// File: rtl/dcc_pkt_store.sv
module dcc_pkt_store #(
  parameter int MAX_BYTES = 4,
  parameter int CNT_W     = 3,
  parameter int PRE_W     = 5,
  parameter int MIN_PRE   = 14,
  localparam int BI_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   valid,
  input  logic [8*MAX_BYTES-1:0] bytes_in,
  input  logic [CNT_W-1:0]       count_in,
  input  logic [PRE_W-1:0]       pre_in,
  input  logic [BI_W-1:0]        byte_sel,
  output logic [7:0]             cur_byte,
  output logic [BI_W-1:0]        last_idx,
  output logic [PRE_W-1:0]       pre_len
);
  import dcc_wave_pkg::*;

  logic [8*MAX_BYTES-1:0] bytes_q;

  assign cur_byte = bytes_q[8*byte_sel +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q  <= '0;
      last_idx <= '0;
      pre_len  <= PRE_W'(MIN_PRE);
    end else if (load) begin
      if (valid) begin
        bytes_q  <= bytes_in;
        last_idx <= BI_W'(clamp_count(int'(count_in), MAX_BYTES) - 1);
        pre_len  <= PRE_W'(clamp_pre(int'(pre_in), MIN_PRE));
      end else begin
        for (int i = 0; i < MAX_BYTES; i++)
          bytes_q[8*i +: 8] <= (i == 1) ? 8'h00 : 8'hFF;
        last_idx <= BI_W'(2);
        pre_len  <= PRE_W'(MIN_PRE);
      end
    end
  end

endmodule

// File: rtl/dcc_cutout_gen.sv
module dcc_cutout_gen #(
  parameter int MAX_BYTES = 4,
  parameter int CNT_W     = 3,
  parameter int PRE_W     = 5,
  parameter int MIN_PRE   = 14,
  parameter int ONE_HALF  = 56,
  parameter int ZERO_HALF = 105,
  parameter int HZ_HIGH   = 15,
  parameter int HZ_LOW    = 100,
  parameter int GAP_T     = 26,
  parameter int WIN1_T    = 177,
  parameter int WIN_END_T = 454
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_us,
  input  logic                   pkt_valid,
  output logic                   pkt_ready,
  input  logic [8*MAX_BYTES-1:0] pkt_bytes,
  input  logic [CNT_W-1:0]       pkt_count,
  input  logic [PRE_W-1:0]       pkt_preamble,
  input  logic                   cutout_en,
  input  logic                   half_zero_en,
  output logic                   track_pol,
  output logic                   cutout_act,
  output logic                   cut_start_stb,
  output logic                   cut_mid_stb,
  output logic                   cut_end_stb
);
  import dcc_wave_pkg::*;

  localparam int TW   = $clog2(WIN_END_T + 1);
  localparam int BI_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  phase_t           phase;
  stage_t           stage;
  logic [PRE_W-1:0] pre_cnt;
  logic [BI_W-1:0]  byte_idx;
  logic [2:0]       bit_pos;
  logic             post_half;
  logic             start_q, mid_q, end_q;

  // Named internal events for the checker.
  logic             seg_end;
  logic             in_init;
  logic             take_pkt;
  kind_t            kind;
  logic [TW-1:0]    seg_len;
  int               len_i;
  logic [7:0]       cur_byte;
  logic [BI_W-1:0]  last_idx;
  logic [PRE_W-1:0] pre_len;

  assign in_init  = (phase == PH_INIT);
  assign take_pkt = in_init ||
                    (seg_end && phase == PH_B &&
                     (stage == ST_POST || (stage == ST_END && !cutout_en)));
  assign pkt_ready = rst_n && take_pkt;

  dcc_pkt_store #(
    .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .PRE_W(PRE_W), .MIN_PRE(MIN_PRE)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .load(take_pkt), .valid(pkt_valid),
    .bytes_in(pkt_bytes), .count_in(pkt_count), .pre_in(pkt_preamble),
    .byte_sel(byte_idx), .cur_byte(cur_byte), .last_idx(last_idx), .pre_len(pre_len)
  );

  always_comb begin
    case (stage)
      ST_START: kind = BK_ZERO;
      ST_DATA:  kind = cur_byte[bit_pos] ? BK_ONE : BK_ZERO;
      ST_POST:  kind = post_half ? BK_HALF : BK_ONE;
      default:  kind = BK_ONE;
    endcase
  end

  always_comb begin
    case (phase)
      PH_A:    len_i = half_ticks(kind, 1'b0, ONE_HALF, ZERO_HALF, HZ_HIGH, HZ_LOW);
      PH_B:    len_i = half_ticks(kind, 1'b1, ONE_HALF, ZERO_HALF, HZ_HIGH, HZ_LOW);
      PH_GAP:  len_i = GAP_T;
      PH_WIN1: len_i = WIN1_T;
      PH_WIN2: len_i = WIN_END_T - WIN1_T;
      default: len_i = 1;
    endcase
    seg_len = TW'(len_i);
  end

  dcc_seg_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .restart(in_init),
    .len(seg_len), .seg_end(seg_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_INIT;
      stage     <= ST_PRE;
      pre_cnt   <= '0;
      byte_idx  <= '0;
      bit_pos   <= 3'd7;
      post_half <= 1'b0;
      start_q   <= 1'b0;
      mid_q     <= 1'b0;
      end_q     <= 1'b0;
    end else begin
      start_q <= 1'b0;
      mid_q   <= 1'b0;
      end_q   <= 1'b0;
      if (in_init) begin
        phase    <= PH_A;
        stage    <= ST_PRE;
        pre_cnt  <= '0;
        byte_idx <= '0;
      end else if (seg_end) begin
        case (phase)
          PH_A: phase <= PH_B;
          PH_B: begin
            phase <= PH_A;
            case (stage)
              ST_PRE: begin
                if (pre_cnt == pre_len - PRE_W'(1)) begin
                  stage   <= ST_START;
                  pre_cnt <= '0;
                end else begin
                  pre_cnt <= pre_cnt + PRE_W'(1);
                end
              end
              ST_START: begin
                stage   <= ST_DATA;
                bit_pos <= 3'd7;
              end
              ST_DATA: begin
                if (bit_pos == 3'd0) begin
                  if (byte_idx == last_idx) begin
                    stage <= ST_END;
                  end else begin
                    byte_idx <= byte_idx + BI_W'(1);
                    stage    <= ST_START;
                  end
                end else begin
                  bit_pos <= bit_pos - 3'd1;
                end
              end
              ST_END: begin
                if (cutout_en) begin
                  phase <= PH_GAP;
                end else begin
                  stage    <= ST_PRE;
                  pre_cnt  <= '0;
                  byte_idx <= '0;
                end
              end
              default: begin
                stage    <= ST_PRE;
                pre_cnt  <= '0;
                byte_idx <= '0;
              end
            endcase
          end
          PH_GAP: begin
            phase   <= PH_WIN1;
            start_q <= 1'b1;
          end
          PH_WIN1: begin
            phase <= PH_WIN2;
            mid_q <= 1'b1;
          end
          PH_WIN2: begin
            phase     <= PH_A;
            stage     <= ST_POST;
            post_half <= half_zero_en;
            end_q     <= 1'b1;
          end
          default: phase <= PH_A;
        endcase
      end
    end
  end

  assign track_pol     = (phase == PH_A) || (phase == PH_GAP) ||
                         (phase == PH_WIN1) || (phase == PH_WIN2);
  assign cutout_act    = (phase == PH_WIN1) || (phase == PH_WIN2);
  assign cut_start_stb = start_q;
  assign cut_mid_stb   = mid_q;
  assign cut_end_stb   = end_q;

endmodule

// File: rtl/dcc_cutout_chk.sv
module dcc_cutout_chk (
  input logic clk,
  input logic rst_n,
  input logic track_pol,
  input logic cutout_act,
  input logic cut_start_stb,
  input logic cut_mid_stb,
  input logic cut_end_stb,
  input logic pkt_ready,
  input logic seg_end,
  input logic in_init
);

  assert_strobes_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cut_start_stb, cut_mid_stb, cut_end_stb}));

  assert_start_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cut_start_stb |-> (cutout_act && !$past(cutout_act)));

  assert_end_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cut_end_stb |-> (!cutout_act && $past(cutout_act)));

  assert_mid_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cut_mid_stb |-> (cutout_act && $past(cutout_act)));

  assert_rise_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cutout_act) |-> cut_start_stb);

  assert_pol_high_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cutout_act |-> track_pol);

  assert_no_req_in_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cutout_act |-> !pkt_ready);

  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |=> !pkt_ready);

  assert_tick_paced_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(track_pol)) |-> ($past(seg_end) || $past(in_init)));

endmodule

bind dcc_cutout_gen dcc_cutout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .track_pol(track_pol), .cutout_act(cutout_act),
  .cut_start_stb(cut_start_stb), .cut_mid_stb(cut_mid_stb), .cut_end_stb(cut_end_stb),
  .pkt_ready(pkt_ready), .seg_end(seg_end), .in_init(in_init)
);

// File: tb/sim_dcc_cutout_gen.sv
module sim_dcc_cutout_gen;
  localparam int CLK_T = 10;
  localparam int MAXB  = 4;
  localparam int WDOG  = 190000;

  logic clk = 1'b0;
  logic rst_n, tick_us, pkt_valid, cutout_en, half_zero_en;
  logic [8*MAXB-1:0] pkt_bytes;
  logic [2:0] pkt_count;
  logic [4:0] pkt_preamble;
  logic pkt_ready, track_pol, cutout_act, cut_start_stb, cut_mid_stb, cut_end_stb;

  dcc_cutout_gen #(.MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_bytes(pkt_bytes), .pkt_count(pkt_count),
    .pkt_preamble(pkt_preamble), .cutout_en(cutout_en), .half_zero_en(half_zero_en),
    .track_pol(track_pol), .cutout_act(cutout_act), .cut_start_stb(cut_start_stb),
    .cut_mid_stb(cut_mid_stb), .cut_end_stb(cut_end_stb)
  );

  always #(CLK_T/2) clk = ~clk;

  int total = 0, bad = 0, hs_n = 0, compared = 0;
  int tcount = 0, seg_t0 = 0, rise_t = 0;
  bit last_tick = 0, started = 0, done = 0, hs_flag = 0, reset_checked = 0, prev_stb = 0;
  logic [1:0] prev_pair;
  int q_pol[$], q_cut[$], q_len[$];
  string q_tag[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int half_len(int k, bit second);
    if (k == 1) return 105;
    if (k == 2) return second ? 100 : 15;
    return 56;
  endfunction

  task automatic push_seg(int p, int c, int l, string tag);
    q_pol.push_back(p); q_cut.push_back(c); q_len.push_back(l); q_tag.push_back(tag);
  endtask

  // kind: 0 one, 1 zero, 2 half-zero
  task automatic push_bit(int k, string tag);
    push_seg(1, 0, half_len(k, 1'b0), tag);
    push_seg(0, 0, half_len(k, 1'b1), tag);
  endtask

  task automatic push_body(bit v, logic [8*MAXB-1:0] by, int cnt, int pre);
    int n, p;
    logic [7:0] b;
    string t;
    if (!v) begin n = 3; p = 14; end
    else begin
      n = (cnt < 1) ? 1 : ((cnt > MAXB) ? MAXB : cnt);
      p = (pre < 14) ? 14 : pre;
    end
    for (int i = 0; i < p; i++) push_bit(0, v ? "R3" : "R8");
    for (int i = 0; i < n; i++) begin
      b = v ? by[8*i +: 8] : ((i == 1) ? 8'h00 : 8'hFF);
      push_bit(1, v ? "R3" : "R8");
      for (int j = 7; j >= 0; j--) begin
        t = !v ? "R8" : (b[j] ? "R2" : "R1");
        push_bit(b[j] ? 0 : 1, t);
      end
    end
    push_bit(0, "R3");
  endtask

  task automatic push_tail(bit cen, bit hz);
    if (cen) begin
      push_seg(1, 0, 26, "R4");
      push_seg(1, 1, 454, "R4");
      push_bit(hz ? 2 : 0, "R6");
    end
  endtask

  task automatic finish_up();
    done = 1;
    chk(compared >= 200, "R3", "segments compared", compared, 200);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // setup(k): settings for packet k-1's tail, data for packet k
  task automatic setup(int k);
    case (k)
      0: begin pkt_valid = 1; pkt_count = 1; pkt_preamble = 14;
               pkt_bytes = $urandom; cutout_en = 1; half_zero_en = 1; end
      1: begin cutout_en = 1; half_zero_en = 1; pkt_valid = 0; end
      2: begin cutout_en = 1; half_zero_en = 0; pkt_valid = 1;
               pkt_count = 2; pkt_preamble = 16; pkt_bytes = 32'h00A5_3C81; end
      3: begin cutout_en = 0; pkt_count = 0; pkt_preamble = 10; pkt_bytes = $urandom; end
      4: begin cutout_en = 1; half_zero_en = 1; pkt_count = 7; pkt_preamble = 14;
               pkt_bytes = $urandom; end
      5: begin cutout_en = 1; half_zero_en = 0; pkt_count = 3'(1 + $urandom % 3);
               pkt_preamble = 5'(14 + $urandom % 4); pkt_bytes = $urandom; end
      default: begin
        cutout_en = 1'($urandom % 2); half_zero_en = 1'($urandom % 2);
        pkt_valid = (($urandom % 4) != 0);
        pkt_count = 3'(1 + $urandom % 3); pkt_preamble = 5'(13 + $urandom % 5);
        pkt_bytes = $urandom;
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (tick_us) tcount++;
    last_tick = tick_us;
  end

  initial begin
    int unsigned seed_ret;
    seed_ret = $urandom(32'h5EED);
    rst_n = 0; tick_us = 0;
    setup(0);
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    forever begin
      @(posedge clk);
      #1;
      tick_us = ~tick_us;
      if (hs_flag) begin
        hs_flag = 0;
        setup(hs_n);
        push_tail(cutout_en, half_zero_en);
      end
    end
  end

  always @(negedge clk) begin
    logic [1:0] pair;
    int dur;
    bit any_stb;
    if (!rst_n) begin
      if (!reset_checked) begin
        reset_checked = 1;
        chk(track_pol == 0 && cutout_act == 0, "R9", "pol/cutout in reset",
            {track_pol, cutout_act}, 0);
        chk({cut_start_stb, cut_mid_stb, cut_end_stb} == 0, "R9", "strobes in reset",
            {cut_start_stb, cut_mid_stb, cut_end_stb}, 0);
        chk(pkt_ready == 0, "R9", "ready in reset", pkt_ready, 0);
      end
    end else if (!done) begin
      pair = {track_pol, cutout_act};
      if (started && pair != prev_pair) begin
        chk(last_tick, "R10", "change without tick", 0, 1);
        dur = tcount - seg_t0;
        if (q_len.size() == 0) begin
          chk(0, "R3", "unexpected segment length", dur, 0);
        end else begin
          int ep, ec, el;
          string et;
          ep = q_pol.pop_front(); ec = q_cut.pop_front();
          el = q_len.pop_front(); et = q_tag.pop_front();
          compared++;
          chk(ep == int'(prev_pair[1]) && ec == int'(prev_pair[0]), et, "segment level",
              prev_pair, 2*ep + ec);
          chk(el == dur, et, "segment ticks", dur, el);
        end
        if (!prev_pair[0] && pair[0]) begin
          rise_t = tcount;
          chk(cut_start_stb, "R5", "start strobe at cutout rise", cut_start_stb, 1);
        end
        if (prev_pair[0] && !pair[0]) begin
          chk(cut_end_stb, "R5", "end strobe at cutout fall", cut_end_stb, 1);
          chk(tcount - rise_t == 454, "R5", "end strobe ticks", tcount - rise_t, 454);
        end
        prev_pair = pair;
        seg_t0 = tcount;
      end else if (!started && track_pol) begin
        started = 1;
        prev_pair = pair;
        seg_t0 = tcount;
      end
      if (cut_mid_stb) begin
        chk(cutout_act, "R5", "mid strobe inside cutout", cutout_act, 1);
        chk(tcount - rise_t == 177, "R5", "mid strobe ticks", tcount - rise_t, 177);
      end
      any_stb = cut_start_stb || cut_mid_stb || cut_end_stb;
      if ((int'(cut_start_stb) + int'(cut_mid_stb) + int'(cut_end_stb)) > 1)
        chk(0, "R5", "two strobes together", 2, 1);
      if (any_stb && prev_stb) chk(0, "R5", "strobe longer than one cycle", 2, 1);
      prev_stb = any_stb;
      if (pkt_ready) begin
        chk(!cutout_act, "R7", "request during cutout", cutout_act, 0);
        chk(q_len.size() == ((hs_n == 0) ? 0 : 1), "R7", "request point (pending segments)",
            q_len.size(), (hs_n == 0) ? 0 : 1);
        push_body(pkt_valid, pkt_bytes, int'(pkt_count), int'(pkt_preamble));
        hs_n++;
        hs_flag = 1;
        if (hs_n == 9) finish_up();
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "R7", "watchdog expired, requests seen", hs_n, 9);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule